// File: doc/BRIEF.md
# Asynchronous Acknowledge-Paced Bus Master

This block runs one asynchronous read or write at a time on an external parallel bus. The internal side presents a request with a direction flag, an address and write data. The block then drives chip select, address, the write data bus and either output enable or write enable, and keeps the cycle open until the external device answers on an acknowledge input. When the acknowledge arrives, the block samples read data or stops write enable. It then releases the bus and reports the result with a one-cycle done pulse.

The acknowledge pin is asynchronous to the block clock, so it passes through a two-flop synchronizer before the state machine uses it. A configuration bit selects the pin's active level. A programmable start delay keeps the block from looking at the acknowledge too early after the strobes assert. A programmable timeout ends the cycle with an error when the device never answers.

Top module: `async_ack_bus_master`

## Requirements
- R1: While reset is low, and in the first cycle after it, `bus_cs_n`, `bus_oe_n` and `bus_we_n` are 1, `bus_dout_en`, `rsp_done` and `rsp_error` are 0, and `req_ready` is 1.
- R2: A request is taken only while `req_ready` is 1. `req_valid` raised during an access changes neither `bus_addr` nor the access in progress, and produces no extra `rsp_done`.
- R3: The acknowledge is not examined during the first `cfg_start_dly` cycles after the one-cycle setup phase. With the acknowledge already asserted and `cfg_start_dly` of at least 2, `bus_cs_n` is low for exactly `cfg_start_dly + 3` cycles.
- R4: When `cfg_ack_high` is 1 the acknowledge is active at pin level 1. When it is 0 the acknowledge is active at pin level 0, and a pin held at 1 then leads to a timeout.
- R5: If the acknowledge pin becomes active before clock edge k while the block is waiting for it, `rsp_done` is 1 in the cycle after edge k+3 (two synchronizer stages, then a data cycle, then a hold cycle).
- R6: On a read, `rsp_rdata` holds the `bus_din` value present at the edge where the synchronized acknowledge is first seen active. The access completes while the acknowledge is still asserted.
- R7: On a write, `bus_dout` carries the request's write data and `bus_dout_en` is 1 from the setup cycle through the hold cycle. `bus_we_n` is low from the cycle after setup until the acknowledge is seen, and high in the following cycle while `bus_cs_n` is still low.
- R8: If the acknowledge is not seen within `cfg_timeout + 1` waiting cycles, the cycle is aborted: `rsp_done` and `rsp_error` pulse together, with all strobes high.
- R9: `rsp_done` is a single-cycle pulse in a cycle where `bus_cs_n` is high, and `bus_cs_n` stays high for at least one cycle between two accesses.
- R10: `bus_oe_n` is low only on reads and `bus_we_n` only on writes. The two are never low together, and neither is low while `bus_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_ack_high | input | 1 | 1: acknowledge active high, 0: active low |
| cfg_start_dly | input | DLYW | Cycles to wait after setup before checking the acknowledge |
| cfg_timeout | input | TOW | Waiting cycles allowed, minus one, before abort |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Timeout abort, valid with `rsp_done` |
| rsp_rdata | output | DW | Last sampled read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable (read strobe), active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | AW | Bus address |
| bus_dout | output | DW | Bus write data |
| bus_dout_en | output | 1 | Write data driver enable |
| bus_din | input | DW | Bus read data |
| bus_ack | input | 1 | Data acknowledge from the device, asynchronous |

## Verification
The device model raises the acknowledge on a chosen falling edge and records that cycle. For accesses whose acknowledge arrives during the waiting phase, the monitor requires `rsp_done` exactly four falling edges later. For accesses with an early acknowledge, the model counts the cycles that chip select stays low, and the monitor compares that count with `cfg_start_dly + 3`. Read data, captured write data, the error flag and the released strobes are all compared on the falling edge where `rsp_done` is seen, which is the hold cycle. The reset state, and the absence of an extra completion after a request made while busy, are sampled on falling edges a fixed number of cycles after the stimulus.

// File: rtl/abm_pkg.sv
// Package: shared types of the asynchronous acknowledge bus master.
// Assumes: one access at a time; the states are listed in their order of use.
package abm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_START_DLY,
        ST_WAIT_ACK,
        ST_DATA,
        ST_HOLD
    } abm_state_e;

endpackage

// File: rtl/abm_sync.sv
// Module: multi-stage synchronizer for one asynchronous input bit.
// Assumes: the input may change at any time; the output lags by STAGES edges.
module abm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/abm_timer.sv
// Module: loadable down counter that flags when it reaches zero.
// Assumes: load has priority over decrement; decrement at zero is never requested.
module abm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Load a new count or step the current count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/abm_ctrl.sv
// Module: access sequencer. Steps idle, setup, start delay, acknowledge wait,
// data and hold, and shares one counter between the start delay and the timeout.
// Assumes: ack_hit is already synchronized and corrected for polarity.
module abm_ctrl
    import abm_pkg::*;
#(
    parameter int DLYW = 4,
    parameter int TOW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            ack_hit,
    input  logic [DLYW-1:0] cfg_start_dly,
    input  logic [TOW-1:0]  cfg_timeout,
    output abm_state_e      state,
    output logic            accept,
    output logic            capture,
    output logic            err_q
);

    localparam int CW = (DLYW > TOW) ? DLYW : TOW;

    abm_state_e      nxt;
    logic            abort;
    logic            tmr_load;
    logic            tmr_dec;
    logic            tmr_zero;
    logic [CW-1:0]   tmr_val;
    logic [DLYW-1:0] dly_m1;

    assign dly_m1 = cfg_start_dly - DLYW'(1);

    // Next-state decode with the counter controls for each phase.
    always_comb begin
        nxt      = state;
        accept   = 1'b0;
        capture  = 1'b0;
        abort    = 1'b0;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt    = ST_SETUP;
                    accept = 1'b1;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                if (cfg_start_dly == '0) begin
                    nxt     = ST_WAIT_ACK;
                    tmr_val = CW'(cfg_timeout);
                end else begin
                    nxt     = ST_START_DLY;
                    tmr_val = CW'(dly_m1);
                end
            end
            ST_START_DLY: begin
                if (tmr_zero) begin
                    nxt      = ST_WAIT_ACK;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(cfg_timeout);
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_WAIT_ACK: begin
                if (ack_hit) begin
                    nxt     = ST_DATA;
                    capture = 1'b1;
                end else if (tmr_zero) begin
                    nxt   = ST_HOLD;
                    abort = 1'b1;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_DATA: nxt = ST_HOLD;
            ST_HOLD: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Remember a timeout abort until the next request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (accept) begin
            err_q <= 1'b0;
        end else if (abort) begin
            err_q <= 1'b1;
        end
    end

    abm_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

endmodule

// File: rtl/async_ack_bus_master.sv
// Module: top of the asynchronous acknowledge bus master. Holds the request
// registers and read data and decodes the bus strobes from the sequencer state.
// Assumes: bus_ack is asynchronous; the device holds bus_din valid while it
// asserts the acknowledge.
module async_ack_bus_master
    import abm_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int DLYW = 4,
    parameter int TOW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_ack_high,
    input  logic [DLYW-1:0] cfg_start_dly,
    input  logic [TOW-1:0]  cfg_timeout,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_done,
    output logic            rsp_error,
    output logic [DW-1:0]   rsp_rdata,
    output logic            bus_cs_n,
    output logic            bus_oe_n,
    output logic            bus_we_n,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_dout,
    output logic            bus_dout_en,
    input  logic [DW-1:0]   bus_din,
    input  logic            bus_ack
);

    abm_state_e    state;
    logic          accept;
    logic          capture;
    logic          err_q;
    logic          ack_s;
    logic          ack_hit;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          in_cycle;
    logic          strobe;

    abm_sync #(.STAGES(2)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_ack),
        .q     (ack_s)
    );

    assign ack_hit = (ack_s == cfg_ack_high);

    abm_ctrl #(.DLYW(DLYW), .TOW(TOW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .ack_hit       (ack_hit),
        .cfg_start_dly (cfg_start_dly),
        .cfg_timeout   (cfg_timeout),
        .state         (state),
        .accept        (accept),
        .capture       (capture),
        .err_q         (err_q)
    );

    // Latch direction, address and write data when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the read bus on the edge where the acknowledge is first seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (capture && !wr_q) begin
            rsp_rdata <= bus_din;
        end
    end

    // Decode the phases that hold chip select and the strobes.
    always_comb begin
        in_cycle = (state == ST_SETUP) || (state == ST_START_DLY) ||
                   (state == ST_WAIT_ACK) || (state == ST_DATA);
        strobe   = (state == ST_START_DLY) || (state == ST_WAIT_ACK);
    end

    assign bus_cs_n    = !in_cycle;
    assign bus_oe_n    = !(strobe && !wr_q);
    assign bus_we_n    = !(strobe && wr_q);
    assign bus_addr    = addr_q;
    assign bus_dout    = wdata_q;
    assign bus_dout_en = wr_q && (in_cycle || (state == ST_HOLD));
    assign req_ready   = (state == ST_IDLE);
    assign rsp_done    = (state == ST_HOLD);
    assign rsp_error   = (state == ST_HOLD) && err_q;

endmodule

// File: rtl/abm_checker.sv
// Module: protocol checker for the bus master, attached by bind.
// Assumes: only the top-level ports are observed.
module abm_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          rsp_error,
    input logic          bus_cs_n,
    input logic          bus_oe_n,
    input logic          bus_we_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_dout_en
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n)); // R10

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_cs_n); // R10

    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |=> bus_cs_n); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R9

    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> bus_cs_n); // R9

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_done && bus_oe_n && bus_we_n)); // R8

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr)); // R2

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && !bus_dout_en)); // R2

    AST_WE_RELEASE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_we_n) && !bus_cs_n) |-> bus_dout_en); // R7

endmodule

bind async_ack_bus_master abm_checker #(.AW(AW)) u_abm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .rsp_error   (rsp_error),
    .bus_cs_n    (bus_cs_n),
    .bus_oe_n    (bus_oe_n),
    .bus_we_n    (bus_we_n),
    .bus_addr    (bus_addr),
    .bus_dout_en (bus_dout_en)
);

// File: tb/async_ack_bus_master_test.sv
// Bench: scoreboard driven. The driver task queues the expected result of each
// access, a device model answers on the bus, and the monitor compares at done.
module async_ack_bus_master_test;

    localparam logic [15:0] KEY = 16'h5A3C;

    typedef struct {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
        logic        err;
        int          cs_exp;
        bit          chk_lat;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ack_high = 1'b1;
    logic [3:0]  cfg_start_dly = '0;
    logic [7:0]  cfg_timeout = 8'd20;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic        rsp_error;
    logic [15:0] rsp_rdata;
    logic        bus_cs_n;
    logic        bus_oe_n;
    logic        bus_we_n;
    logic [15:0] bus_addr;
    logic [15:0] bus_dout;
    logic        bus_dout_en;
    logic [15:0] bus_din = '0;
    logic        bus_ack = 1'b0;

    async_ack_bus_master #(.AW(16), .DW(16), .DLYW(4), .TOW(8)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_ack_high  (cfg_ack_high),
        .cfg_start_dly (cfg_start_dly),
        .cfg_timeout   (cfg_timeout),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_done      (rsp_done),
        .rsp_error     (rsp_error),
        .rsp_rdata     (rsp_rdata),
        .bus_cs_n      (bus_cs_n),
        .bus_oe_n      (bus_oe_n),
        .bus_we_n      (bus_we_n),
        .bus_addr      (bus_addr),
        .bus_dout      (bus_dout),
        .bus_dout_en   (bus_dout_en),
        .bus_din       (bus_din),
        .bus_ack       (bus_ack)
    );

    always #(4ns) clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    done_cnt = 0;
    bit    finished = 1'b0;
    item_t exp_q[$];

    // Device model state.
    int          dev_lat = 1;
    logic        dev_pol = 1'b1;
    bit          acked = 1'b0;
    int          strobe_n = 0;
    int          ack_cyc = 0;
    int          cs_low = 0;
    logic        cs_prev = 1'b1;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_en_seen = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor first, then device model, on every falling edge.
    always @(negedge clk) begin
        item_t it;
        cyc++;
        if (rsp_done && rst_n) begin
            done_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected done", 32'd1, 32'd0);
            end else begin
                it = exp_q.pop_front();
                chk(rsp_error == it.err, it.tag, "error flag", 32'(rsp_error), 32'(it.err));
                chk(bus_cs_n && bus_oe_n && bus_we_n, "R9", "strobes high at done",
                    {29'd0, bus_cs_n, bus_oe_n, bus_we_n}, 32'd7);
                if (!it.err && !it.wr)
                    chk(rsp_rdata == (it.addr ^ KEY), it.tag, "read data",
                        32'(rsp_rdata), 32'(it.addr ^ KEY));
                if (!it.err && it.wr) begin
                    chk(wr_addr == it.addr && wr_data == it.data && wr_en_seen, it.tag,
                        "write addr/data at ack", {wr_addr, wr_data}, {it.addr, it.data});
                    chk(bus_dout_en && bus_dout == it.data, "R7", "write data held in hold",
                        {15'd0, bus_dout_en, bus_dout}, {16'd1, it.data});
                end
                if (it.cs_exp >= 0)
                    chk(cs_low == it.cs_exp, "R3", "chip select low cycles",
                        32'(cs_low), 32'(it.cs_exp));
                if (it.chk_lat)
                    chk(cyc - ack_cyc == 4, "R5", "ack to done latency",
                        32'(cyc - ack_cyc), 32'd4);
            end
        end
        // Device model.
        if (!bus_cs_n) begin
            if (cs_prev) cs_low = 1;
            else         cs_low++;
        end
        cs_prev = bus_cs_n;
        if (bus_cs_n) begin
            strobe_n = 0;
            acked    = 1'b0;
        end else if (!bus_oe_n || !bus_we_n) begin
            strobe_n++;
            if (!acked && strobe_n >= dev_lat) begin
                acked   = 1'b1;
                ack_cyc = cyc;
                bus_din = bus_addr ^ KEY;
                if (!bus_we_n) begin
                    wr_addr    = bus_addr;
                    wr_data    = bus_dout;
                    wr_en_seen = bus_dout_en;
                end
            end
        end
        bus_ack = acked ? dev_pol : !dev_pol;
        // Watchdog.
        if (cyc > 50000 && !finished) begin
            finished = 1'b1;
            chk(1'b0, "R9", "watchdog expired", 32'(cyc), 32'd50000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic set_pol(input logic pol);
        @(negedge clk);
        dev_pol      = pol;
        cfg_ack_high = pol;
        repeat (4) @(negedge clk);
    endtask

    task automatic access(input logic wr, input logic [15:0] addr, input logic [15:0] wdata,
                          input int dly, input int tmo, input int lat, input logic err,
                          input int cs_exp, input bit chk_lat, input string tag);
        item_t it;
        int    start;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_start_dly = 4'(dly);
        cfg_timeout   = 8'(tmo);
        dev_lat       = lat;
        it.wr = wr; it.addr = addr; it.data = wdata; it.err = err;
        it.cs_exp = cs_exp; it.chk_lat = chk_lat; it.tag = tag;
        exp_q.push_back(it);
        start     = done_cnt;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_cnt == start) @(negedge clk);
    endtask

    initial begin
        int start;
        item_t it;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held.
        chk(bus_cs_n && bus_oe_n && bus_we_n && !bus_dout_en && !rsp_done && !rsp_error
            && req_ready, "R1", "reset outputs",
            {25'd0, bus_cs_n, bus_oe_n, bus_we_n, bus_dout_en, rsp_done, rsp_error, req_ready},
            32'h71);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cs_n && bus_oe_n && bus_we_n && !bus_dout_en && !rsp_done && req_ready,
            "R1", "outputs after reset",
            {26'd0, bus_cs_n, bus_oe_n, bus_we_n, bus_dout_en, rsp_done, req_ready}, 32'h39);

        set_pol(1'b1);
        access(1'b0, 16'h1234, 16'h0, 0, 20, 1, 1'b0, -1, 1'b0, "R6");
        access(1'b1, 16'h0042, 16'hBEEF, 1, 20, 3, 1'b0, -1, 1'b0, "R7");
        access(1'b0, 16'h0F0F, 16'h0, 1, 20, 5, 1'b0, -1, 1'b1, "R5");
        access(1'b1, 16'h7777, 16'hC001, 2, 20, 6, 1'b0, -1, 1'b1, "R7");
        access(1'b0, 16'h2468, 16'h0, 6, 20, 1, 1'b0, 9, 1'b0, "R3");
        access(1'b0, 16'h1357, 16'h0, 3, 20, 1, 1'b0, 6, 1'b0, "R3");
        for (int i = 0; i < 4; i++) begin
            access(i[0], 16'(16'h3000 + i * 16'h0111), 16'(16'hA000 + i), 0, 20, 2,
                   1'b0, -1, 1'b0, "R9");
        end
        access(1'b0, 16'h4444, 16'h0, 2, 6, 1000, 1'b1, -1, 1'b0, "R8");
        access(1'b1, 16'h5555, 16'h9999, 0, 3, 1000, 1'b1, -1, 1'b0, "R8");
        access(1'b0, 16'h6666, 16'h0, 0, 20, 2, 1'b0, -1, 1'b0, "R8");

        set_pol(1'b0);
        access(1'b0, 16'h8001, 16'h0, 0, 20, 2, 1'b0, -1, 1'b0, "R4");
        access(1'b1, 16'h8002, 16'h1111, 1, 20, 5, 1'b0, -1, 1'b1, "R4");
        access(1'b0, 16'h8003, 16'h0, 1, 5, 1000, 1'b1, -1, 1'b0, "R4");
        set_pol(1'b1);

        // R2: a request raised during an access is ignored.
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_start_dly = 4'd1;
        cfg_timeout   = 8'd30;
        dev_lat       = 8;
        it.wr = 1'b0; it.addr = 16'h0C0C; it.data = '0; it.err = 1'b0;
        it.cs_exp = -1; it.chk_lat = 1'b0; it.tag = "R2";
        exp_q.push_back(it);
        start     = done_cnt;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 16'h0C0C;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 16'hFFFF;
        req_wdata = 16'h1234;
        repeat (2) @(negedge clk);
        chk(bus_addr == 16'h0C0C, "R2", "address during busy request",
            32'(bus_addr), 32'h0C0C);
        req_valid = 1'b0;
        while (done_cnt == start) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(done_cnt == start + 1, "R2", "completions after busy request",
            32'(done_cnt - start), 32'd1);
        chk(bus_cs_n && req_ready, "R2", "idle after busy request",
            {30'd0, bus_cs_n, req_ready}, 32'd3);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule